// File: doc/BRIEF.md
# Completion Signal Update Sequencer

When a kernel or barrier packet finishes, a packet processor or dispatcher hands this block the address of a completion signal. The block then updates that signal in memory through a single request/response memory master port. It reads the 64-bit signal value, adds a signed step (minus one by default), and writes the sum back. Alongside this it reads the signal's mailbox word. If the mailbox holds a nonzero word, the signal is interruptible. In that case the block fetches the 64-bit event identifier and writes it into the mailbox, which clears the pending event.

Incoming handles wait in a small queue, so the caller is never held up by memory latency. Only one signal is processed at a time. Each memory request carries a one-bit path tag, and every request gets exactly one response carrying the same tag. This includes writes, whose response is an acknowledge.

The block reports two things. A one-cycle done pulse marks each retired handle. An event strobe, carrying the identifier, marks each mailbox that was cleared.

Top module: `signal_update_seq`

## Requirements
- R1: The value word at handle+VAL_OFS (default 8) is read from memory, and DIFF (default -1) is added to the read data modulo 2^64. The sum is written back to the same address with tag 0, so a value of zero becomes all ones.
- R2: Once a request starts, the value read (tag 0) and the mailbox read at handle+MBOX_OFS (default 16, tag 1) are both issued before either one needs its response. Neither read waits for the other.
- R3: If the mailbox read returns zero, the mailbox path ends and no further mailbox-path access is made for that handle.
- R4: If the mailbox read returns a nonzero word, the block reads the event identifier at handle+EVT_OFS (default 24, tag 1). It then writes that identifier to handle+MBOX_OFS with tag 1.
- R5: `evt_valid` is high for exactly the cycle in which the response to the mailbox clearing write is presented, with `evt_id` equal to the identifier that was read.
- R6: `done_valid` pulses for one cycle with `done_handle`. The pulse comes in the cycle after the later of two responses: the value write acknowledge, and the end of the mailbox path (a zero mailbox read or the clear acknowledge). Handles retire in acceptance order, one in flight at a time.
- R7: Up to DEPTH (default 4) waiting handles are queued in order. `req_full` is high while DEPTH handles wait, and a `req_valid` offered while `req_full` is high is ignored.
- R8: After reset, `req_full`, `mem_req_valid`, `done_valid` and `evt_valid` are all low.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request's address, direction, data and tag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Completion handle offered |
| req_handle | input | AW | Signal handle (byte address) |
| req_full | output | 1 | Handle queue full; offers are ignored |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | AW | Byte address of the 64-bit word |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_wdata | output | 64 | Write data |
| mem_req_tag | output | 1 | 0 = value path, 1 = mailbox path |
| mem_rsp_valid | input | 1 | Response (read data or write acknowledge) |
| mem_rsp_tag | input | 1 | Tag of the request answered |
| mem_rsp_rdata | input | 64 | Read data |
| done_valid | output | 1 | One-cycle retire pulse |
| done_handle | output | AW | Handle that retired |
| evt_valid | output | 1 | Mailbox event cleared this cycle |
| evt_id | output | 64 | Cleared event identifier |

## Verification
The bench builds the block with its defaults: a 32-bit handle, a queue depth of 4, offsets 8, 16 and 24, and a step of minus one. With a depth of only 4, six offers against a stalled memory port fill the queue and push one offer into the ignored case. Random ready and response latencies make the mailbox request wait while the value path turns around. They also let a response arrive while a request is being held.

// File: rtl/signal_update_seq.sv
module signal_update_seq #(
  parameter int AW = 32,
  parameter int DEPTH = 4,
  parameter int VAL_OFS = 8,
  parameter int MBOX_OFS = 16,
  parameter int EVT_OFS = 24,
  parameter logic signed [63:0] DIFF = -64'sd1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_handle,
  output logic          req_full,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic          mem_req_write,
  output logic [63:0]   mem_req_wdata,
  output logic          mem_req_tag,
  input  logic          mem_rsp_valid,
  input  logic          mem_rsp_tag,
  input  logic [63:0]   mem_rsp_rdata,
  output logic          done_valid,
  output logic [AW-1:0] done_handle,
  output logic          evt_valid,
  output logic [63:0]   evt_id
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [2:0] {V_RD, V_RDW, V_WR, V_WRW, V_DN} vst_t;
  typedef enum logic [2:0] {M_RD, M_RDW, M_EV, M_EVW, M_CL, M_CLW, M_DN} mst_t;

  logic [AW-1:0] fifo [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          busy, lock_m;
  logic [AW-1:0] cur;
  logic [63:0]   vdata, evdata;
  vst_t          v_st;
  mst_t          m_st;

  logic push, pop, v_iss, m_iss, sel_v, fire, rsp_v, rsp_m;

  assign req_full = (cnt == CW'(DEPTH));
  assign push     = req_valid && !req_full;
  assign pop      = !busy && (cnt != '0);
  assign v_iss    = busy && (v_st == V_RD || v_st == V_WR);
  assign m_iss    = busy && (m_st == M_RD || m_st == M_EV || m_st == M_CL);
  assign sel_v    = v_iss && !lock_m;
  assign fire     = mem_req_valid && mem_req_ready;
  assign rsp_v    = mem_rsp_valid && !mem_rsp_tag;
  assign rsp_m    = mem_rsp_valid && mem_rsp_tag;

  assign mem_req_valid = v_iss || m_iss;
  assign mem_req_tag   = !sel_v;
  assign mem_req_write = sel_v ? (v_st == V_WR) : (m_st == M_CL);
  assign mem_req_wdata = sel_v ? vdata : evdata;
  assign mem_req_addr  = cur + (sel_v ? AW'(VAL_OFS) :
                                (m_st == M_EV) ? AW'(EVT_OFS) : AW'(MBOX_OFS));

  assign done_valid  = busy && v_st == V_DN && m_st == M_DN;
  assign done_handle = cur;
  assign evt_valid   = rsp_m && m_st == M_CLW;
  assign evt_id      = evdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      busy <= 1'b0; lock_m <= 1'b0; cur <= '0;
      vdata <= '0; evdata <= '0;
      v_st <= V_DN; m_st <= M_DN;
    end else begin
      if (push) begin
        fifo[wp] <= req_handle;
        wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      end
      if (pop) begin
        cur  <= fifo[rp];
        rp   <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
        busy <= 1'b1;
        v_st <= V_RD;
        m_st <= M_RD;
      end
      cnt <= cnt + CW'(push) - CW'(pop);
      if (done_valid) busy <= 1'b0;
      lock_m <= mem_req_valid && !mem_req_ready && !sel_v;

      if (fire && sel_v)
        v_st <= (v_st == V_RD) ? V_RDW : V_WRW;
      else if (rsp_v && v_st == V_RDW) begin
        vdata <= mem_rsp_rdata + DIFF;
        v_st  <= V_WR;
      end else if (rsp_v && v_st == V_WRW)
        v_st <= V_DN;

      if (fire && !sel_v)
        m_st <= (m_st == M_RD) ? M_RDW : (m_st == M_EV) ? M_EVW : M_CLW;
      else if (rsp_m && m_st == M_RDW)
        m_st <= (mem_rsp_rdata == 64'd0) ? M_DN : M_EV;
      else if (rsp_m && m_st == M_EVW) begin
        evdata <= mem_rsp_rdata;
        m_st   <= M_CL;
      end else if (rsp_m && m_st == M_CLW)
        m_st <= M_DN;
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata) && $stable(mem_req_tag));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  assert_evt_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid && m_st == M_DN);

  assert_zero_mbox_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_m && m_st == M_RDW && mem_rsp_rdata == 64'd0 |=> m_st == M_DN);

  assert_full_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_full && req_valid |=> cnt <= $past(cnt));

  assert_writeback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_v && v_st == V_RDW |=> vdata == $past(mem_rsp_rdata) + DIFF);
endmodule

// File: tb/signal_update_seq_bench.sv
module signal_update_seq_bench;
  localparam int AW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, mem_req_ready = 1'b0;
  logic [AW-1:0] req_handle = '0;
  logic mem_rsp_valid = 1'b0, mem_rsp_tag = 1'b0;
  logic [63:0] mem_rsp_rdata = '0;
  logic req_full, mem_req_valid, mem_req_write, mem_req_tag, done_valid, evt_valid;
  logic [AW-1:0] mem_req_addr, done_handle;
  logic [63:0] mem_req_wdata, evt_id;

  always #5 clk = ~clk;

  signal_update_seq u_signal_update_seq (.*);

  int vec = 0, bad = 0, cyc = 0, par_seen = 0, full_seen = 0, accepted = 0;
  logic [63:0] mem [int unsigned];
  logic [63:0] init_v [int unsigned];
  logic [63:0] init_m [int unsigned];
  logic [63:0] init_e [int unsigned];
  int unsigned mq[$], tp[$], dropped[$], done_list[$];
  int m_cnt = 0, ready_mode = 0, rsp_kind = -1;
  bit m_busy = 0, v_dn = 0, m_dn = 0, exp_prev = 0, p_push = 0, drop_full = 0;
  int unsigned m_cur = 0, p_h = 0;
  logic [63:0] rsp_dat = '0;
  bit pend[2];
  int sl_cnt[2], sl_kind[2];
  logic [63:0] sl_dat[2];

  function automatic logic [63:0] rd(int unsigned a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setup(int unsigned h, logic [63:0] v, logic [63:0] mb, logic [63:0] ev);
    mem[h+8] = v; mem[h+16] = mb; mem[h+24] = ev;
    init_v[h] = v; init_m[h] = mb; init_e[h] = ev;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) continue;
      begin
        bit pop_n;
        pop_n = !m_busy && m_cnt > 0;
        if (exp_prev) m_busy = 0;
        if (pop_n) begin
          m_cur = mq.pop_front(); m_cnt--; m_busy = 1; v_dn = 0; m_dn = 0;
        end
        if (p_push) begin mq.push_back(p_h); m_cnt++; accepted++; end
        if (rsp_kind == 1) v_dn = 1;
        if ((rsp_kind == 2 && rsp_dat == 0) || rsp_kind == 4) m_dn = 1;
      end
      chk(req_full == (m_cnt == 4), "R7 req_full", 64'(req_full), 64'(m_cnt == 4));
      if (req_full) full_seen++;
      exp_prev = m_busy && v_dn && m_dn;
      chk(done_valid == exp_prev, "R6 done_valid", 64'(done_valid), 64'(exp_prev));
      if (exp_prev) begin
        chk(done_handle == m_cur, "R6 done_handle", 64'(done_handle), 64'(m_cur));
        done_list.push_back(m_cur);
      end
      for (int t = 0; t < 2; t++) if (pend[t]) sl_cnt[t]--;
      rsp_kind = -1; mem_rsp_valid = 0;
      for (int t = 0; t < 2; t++)
        if (rsp_kind < 0 && pend[t] && sl_cnt[t] <= 0) begin
          pend[t] = 0; rsp_kind = sl_kind[t]; rsp_dat = sl_dat[t];
          mem_rsp_valid = 1; mem_rsp_tag = 1'(t); mem_rsp_rdata = sl_dat[t];
        end
      mem_req_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? 1'($urandom % 2) : 1'b0;
      p_push = 0;
      if (tp.size() > 0) begin
        req_valid = 1; req_handle = tp[0];
        if (!req_full) begin p_h = tp.pop_front(); p_push = 1; end
        else if (drop_full) dropped.push_back(tp.pop_front());
      end else req_valid = 0;
      #1;
      chk(evt_valid == (rsp_kind == 4), "R5 evt_valid", 64'(evt_valid), 64'(rsp_kind == 4));
      if (rsp_kind == 4) chk(evt_id == init_e[m_cur], "R5 evt_id", evt_id, init_e[m_cur]);
      if (mem_req_valid && mem_req_ready) begin
        int unsigned off;
        int t, k;
        off = int'(mem_req_addr) - m_cur; t = int'(mem_req_tag); k = -1;
        if (!mem_req_write && t == 0 && off == 8) k = 0;
        else if (mem_req_write && t == 0 && off == 8) begin
          k = 1;
          chk(mem_req_wdata == init_v[m_cur] - 64'd1, "R1 value writeback", mem_req_wdata, init_v[m_cur] - 64'd1);
          mem[mem_req_addr] = mem_req_wdata;
        end else if (!mem_req_write && t == 1 && off == 16) begin
          k = 2;
          if (pend[0] && sl_kind[0] == 0) par_seen++;
        end else if (!mem_req_write && t == 1 && off == 24) begin
          k = 3;
          chk(init_m[m_cur] != 0, "R3 event read after zero mailbox", init_m[m_cur], 64'd1);
        end else if (mem_req_write && t == 1 && off == 16) begin
          k = 4;
          chk(mem_req_wdata == init_e[m_cur], "R4 mailbox clear data", mem_req_wdata, init_e[m_cur]);
          mem[mem_req_addr] = mem_req_wdata;
        end
        chk(k >= 0 && m_busy, "R2 legal request", 64'(mem_req_addr), 64'(m_cur));
        chk(!pend[t], "R2 one outstanding per path", 64'(pend[t]), 64'd0);
        pend[t] = 1; sl_kind[t] = k; sl_cnt[t] = 1 + int'($urandom % 3);
        sl_dat[t] = mem_req_write ? 64'd0 : rd(mem_req_addr);
      end
    end
  end

  task automatic wait_idle();
    int n = 0;
    while ((tp.size() > 0 || m_busy || m_cnt > 0 || p_push) && n < 2000) begin
      @(negedge clk); n++;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk(!req_full && !mem_req_valid && !done_valid && !evt_valid, "R8 reset outputs",
        {60'd0, req_full, mem_req_valid, done_valid, evt_valid}, 64'd0);
    setup('h1000, 64'd5, 64'd0, 64'd0);
    setup('h1040, 64'd0, 64'd0, 64'd0);
    setup('h1080, 64'h123, 64'd7, 64'hABCD);
    ready_mode = 0;
    tp.push_back('h1000); tp.push_back('h1040); tp.push_back('h1080);
    wait_idle();
    setup('h2000, 64'h8000_0000_0000_0000, 64'd1, 64'h55);
    setup('h2040, 64'd1, 64'd0, 64'd9);
    setup('h2080, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF0, 64'd0);
    ready_mode = 1;
    tp.push_back('h2000); tp.push_back('h2040); tp.push_back('h2080);
    wait_idle();
    ready_mode = 2; drop_full = 1;
    for (int i = 0; i < 6; i++) begin
      setup('h3000 + i*64, 64'(100 + i), 64'(i % 2), 64'(32'hE0 + i));
      tp.push_back('h3000 + i*64);
    end
    repeat (30) @(negedge clk);
    chk(full_seen > 0, "R7 queue reached full", 64'(full_seen), 64'd1);
    chk(dropped.size() == 1, "R7 offer while full ignored", 64'(dropped.size()), 64'd1);
    drop_full = 0; ready_mode = 1;
    wait_idle();
    foreach (init_v[h]) begin
      bit is_drop = 0;
      foreach (dropped[i]) if (dropped[i] == h) is_drop = 1;
      if (is_drop) begin
        chk(rd(h+8) == init_v[h], "R7 ignored handle untouched", rd(h+8), init_v[h]);
      end else begin
        chk(rd(h+8) == init_v[h] - 64'd1, "R1 final value", rd(h+8), init_v[h] - 64'd1);
        chk(rd(h+16) == (init_m[h] != 0 ? init_e[h] : 64'd0), "R4 final mailbox",
            rd(h+16), init_m[h] != 0 ? init_e[h] : 64'd0);
      end
    end
    chk(rd('h1040 + 8) == 64'hFFFF_FFFF_FFFF_FFFF, "R1 wrap from zero", rd('h1040 + 8), '1);
    chk(done_list.size() == accepted, "R6 every accepted handle retired", 64'(done_list.size()), 64'(accepted));
    chk(par_seen > 0, "R2 mailbox read issued while value read pending", 64'(par_seen), 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule